// File: doc/BRIEF.md
# Panel Configuration and Frame-Clear Streamer

This block brings a small parallel-bus display panel from "identified" to "ready for pixels". Once pulsed with `start`, it walks a fixed script held in an internal ROM. Each script entry is one command byte followed by zero or more parameter words. Parameter tables used by more than one command are stored once and shared. After the script it observes the sleep-exit settle time, clears the whole frame memory to black, turns the display on, waits a short settle time, and finally issues one memory-write command. That last command is left open, so a downstream pixel source can stream data directly.

Every word goes out over one valid/ready handshake port. A register-select bit marks each word as a command (low) or a parameter (high). Commands occupy the low eight bits of the data word with the upper bits zero. Parameters are zero-extended bytes. The block raises `busy` for the whole run and pulses `done` once the last command has been taken. Physical bus timing and the pixel stream that follows are handled elsewhere.

Top module: `pnlcfg_streamer`

## Requirements
- R1: While reset is held, and after it is released until `start`, `busy`, `done` and `bus_valid` are all low.
- R2: A one-cycle `start` pulse while idle begins a run, with `busy` high from the next cycle. A `start` seen while busy is ignored, and the transaction sequence is unchanged.
- R3: A word is transferred in a cycle where `bus_valid` and `bus_ready` are both high. While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_rs` and `bus_data` hold their values. `bus_rs`=0 marks a command, with the byte in bits 7:0 and zeros above. `bus_rs`=1 marks a parameter, zero-extended from eight bits.
- R4: The run opens with these groups, in this order (hex, command:{parameters}): B0:{00}; B1:{00}; B3:{02,00,00,00,02}; B4:{00}; C0:{0B,63,04,00,00,04,11,00,00}; C1, C2 and C3, each with the timing table {00,00,13,08,08}; C4:{11,01,00,01}; C8, C9 and CA, each with the gamma table {01,02,08,23,03,0C,00,06,00,00,01,00,0C,23,03,08,02,06,00,00}; D0:{07,C5,DC,02,33,0A}; D1:{00,0F,02}; D2, D3 and D4, each with {63,24}; D8:{77,77}.
- R5: Next come the tearing and window groups: 35:{00}; 44:{00,00}; 2A:{00,00,00,EF} (columns 0 to 239); 2B:{00,00,01,8F} (rows 0 to 399).
- R6: Command 11 is then sent with no parameters. `bus_valid` stays low for at least `SLEEP_CYC` cycles after it is accepted.
- R7: Command 2C follows, then exactly `COLS`×`ROWS` parameter words, all of value zero (96,000 with the defaults).
- R8: Command 29 follows. `bus_valid` stays low for at least `ON_CYC` cycles after it is accepted. Command 2C is then sent once with no parameters, and it is the last transfer of the run.
- R9: `done` is high for exactly one cycle, namely the cycle after the final 2C is accepted. In that cycle `busy` is already low, and the bus stays silent afterwards.
- R10: Any pattern of `bus_ready` stalls changes only the timing, not the order, the count or the values of the transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to run the sequence |
| bus_valid | output | 1 | Word on the bus is valid |
| bus_rs | output | 1 | Register select: 0 command, 1 parameter |
| bus_data | output | DATA_W | Command byte or parameter word |
| bus_ready | input | 1 | Bus accepts the word this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume two things about the downstream bus: it honours the handshake, and it eventually raises `bus_ready`. They also assume `start` is a clean synchronous pulse. The stall, quiet-window and fill-count checks are phrased around those accepted transfers. The stimulus keeps within these assumptions by driving `bus_ready` from a fixed periodic pattern that never stalls for more than one cycle. It pulses `start` only on cycles away from the clock edge. The bench shortens the two settle waits through parameters so that the full 96,000-word clear still fits in the run. The clear itself is checked at full size.

// File: rtl/pnlcfg_pkg.sv
package pnlcfg_pkg;

  localparam int N_ENT   = 23;
  localparam int ENT_W   = 5;
  localparam int CNT_W   = 5;
  localparam int PIDX_W  = 6;

  localparam logic [7:0] CMD_SLEEP_OUT = 8'h11;
  localparam logic [7:0] CMD_MEM_WR    = 8'h2C;
  localparam logic [7:0] CMD_DISP_ON   = 8'h29;

  typedef struct packed {
    logic [7:0]        cmd;
    logic [CNT_W-1:0]  cnt;
    logic [PIDX_W-1:0] base;
  } script_ent_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_PAR, ST_SLEEP, ST_FCMD,
    ST_FDAT, ST_ONCMD, ST_ONWAIT, ST_RAMCMD
  } st_t;

  // Shared parameter pool: window tables first, then the register tables.
  function automatic logic [7:0] param_byte(input logic [PIDX_W-1:0] i);
    logic [7:0] b;
    case (i)
      6'd3:  b = 8'hEF;  6'd6:  b = 8'h01;  6'd7:  b = 8'h8F;
      6'd8:  b = 8'h02;  6'd12: b = 8'h02;
      6'd13: b = 8'h0B;  6'd14: b = 8'h63;  6'd15: b = 8'h04;
      6'd18: b = 8'h04;  6'd19: b = 8'h11;
      6'd24: b = 8'h13;  6'd25: b = 8'h08;  6'd26: b = 8'h08;
      6'd27: b = 8'h11;  6'd28: b = 8'h01;  6'd30: b = 8'h01;
      6'd31: b = 8'h01;  6'd32: b = 8'h02;  6'd33: b = 8'h08;
      6'd34: b = 8'h23;  6'd35: b = 8'h03;  6'd36: b = 8'h0C;
      6'd38: b = 8'h06;  6'd41: b = 8'h01;  6'd43: b = 8'h0C;
      6'd44: b = 8'h23;  6'd45: b = 8'h03;  6'd46: b = 8'h08;
      6'd47: b = 8'h02;  6'd48: b = 8'h06;
      6'd51: b = 8'h07;  6'd52: b = 8'hC5;  6'd53: b = 8'hDC;
      6'd54: b = 8'h02;  6'd55: b = 8'h33;  6'd56: b = 8'h0A;
      6'd58: b = 8'h0F;  6'd59: b = 8'h02;
      6'd60: b = 8'h63;  6'd61: b = 8'h24;
      6'd62: b = 8'h77;  6'd63: b = 8'h77;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic script_ent_t script_entry(input logic [ENT_W-1:0] e);
    script_ent_t s;
    case (e)
      5'd0:  s = '{8'hB0, 5'd1,  6'd0};
      5'd1:  s = '{8'hB1, 5'd1,  6'd0};
      5'd2:  s = '{8'hB3, 5'd5,  6'd8};
      5'd3:  s = '{8'hB4, 5'd1,  6'd0};
      5'd4:  s = '{8'hC0, 5'd9,  6'd13};
      5'd5:  s = '{8'hC1, 5'd5,  6'd22};
      5'd6:  s = '{8'hC2, 5'd5,  6'd22};
      5'd7:  s = '{8'hC3, 5'd5,  6'd22};
      5'd8:  s = '{8'hC4, 5'd4,  6'd27};
      5'd9:  s = '{8'hC8, 5'd20, 6'd31};
      5'd10: s = '{8'hC9, 5'd20, 6'd31};
      5'd11: s = '{8'hCA, 5'd20, 6'd31};
      5'd12: s = '{8'hD0, 5'd6,  6'd51};
      5'd13: s = '{8'hD1, 5'd3,  6'd57};
      5'd14: s = '{8'hD2, 5'd2,  6'd60};
      5'd15: s = '{8'hD3, 5'd2,  6'd60};
      5'd16: s = '{8'hD4, 5'd2,  6'd60};
      5'd17: s = '{8'hD8, 5'd2,  6'd62};
      5'd18: s = '{8'h35, 5'd1,  6'd0};
      5'd19: s = '{8'h44, 5'd2,  6'd0};
      5'd20: s = '{8'h2A, 5'd4,  6'd0};
      5'd21: s = '{8'h2B, 5'd4,  6'd4};
      default: s = '{CMD_SLEEP_OUT, 5'd0, 6'd0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pnlcfg_script_rom.sv
module pnlcfg_script_rom
  import pnlcfg_pkg::*;
(
  input  logic [ENT_W-1:0]  ent_idx,
  input  logic [PIDX_W-1:0] par_idx,
  output logic [7:0]        ent_cmd,
  output logic [CNT_W-1:0]  ent_cnt,
  output logic [PIDX_W-1:0] ent_base,
  output logic              ent_last,
  output logic [7:0]        par_val
);
  script_ent_t ent;

  always_comb begin
    ent      = script_entry(ent_idx);
    ent_cmd  = ent.cmd;
    ent_cnt  = ent.cnt;
    ent_base = ent.base;
    ent_last = (ent_idx == ENT_W'(N_ENT - 1));
    par_val  = param_byte(par_idx);
  end
endmodule

// File: rtl/pnlcfg_delay.sv
module pnlcfg_delay #(
  parameter int LONG_CYC  = 6_000_000,
  parameter int SHORT_CYC = 50_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel_long,
  output logic expired
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = sel_long ? CW'(LONG_CYC) : CW'(SHORT_CYC);
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0) && !load;
endmodule

// File: rtl/pnlcfg_fill_ctr.sv
module pnlcfg_fill_ctr #(
  parameter int TOTAL = 96_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int FW = $clog2(TOTAL + 1);

  logic [FW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == FW'(TOTAL - 1));
endmodule

// File: rtl/pnlcfg_streamer.sv
module pnlcfg_streamer
  import pnlcfg_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int COLS      = 240,
  parameter int ROWS      = 400,
  parameter int SLEEP_CYC = 6_000_000,
  parameter int ON_CYC    = 50_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              bus_valid,
  output logic              bus_rs,
  output logic [DATA_W-1:0] bus_data,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done
);
  localparam int FILL_TOTAL = COLS * ROWS;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  st_t               st_q, st_d;
  logic [ENT_W-1:0]  ent_q, ent_d;
  logic [PIDX_W-1:0] pidx_q, pidx_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              done_q, done_d;
  logic              seq_en;

  logic [7:0]        ent_cmd, par_val;
  logic [CNT_W-1:0]  ent_cnt;
  logic [PIDX_W-1:0] ent_base;
  logic              ent_last;
  logic              tmr_load, tmr_long, tmr_exp;
  logic              fill_clr, fill_inc, fill_last;
  logic              acc;

  pnlcfg_script_rom u_rom (
    .ent_idx (ent_q),
    .par_idx (pidx_q),
    .ent_cmd (ent_cmd),
    .ent_cnt (ent_cnt),
    .ent_base(ent_base),
    .ent_last(ent_last),
    .par_val (par_val)
  );

  pnlcfg_delay #(.LONG_CYC(SLEEP_CYC), .SHORT_CYC(ON_CYC)) u_delay (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (tmr_load),
    .sel_long(tmr_long),
    .expired (tmr_exp)
  );

  pnlcfg_fill_ctr #(.TOTAL(FILL_TOTAL)) u_fill (
    .clk  (clk),
    .rst_n(srst_n),
    .clr  (fill_clr),
    .inc  (fill_inc),
    .last (fill_last)
  );

  // bus word selection
  always_comb begin
    bus_valid = 1'b0;
    bus_rs    = 1'b0;
    bus_data  = '0;
    case (st_q)
      ST_CMD:    begin bus_valid = 1'b1; bus_data = DATA_W'(ent_cmd); end
      ST_PAR:    begin bus_valid = 1'b1; bus_rs = 1'b1; bus_data = DATA_W'(par_val); end
      ST_FCMD,
      ST_RAMCMD: begin bus_valid = 1'b1; bus_data = DATA_W'(CMD_MEM_WR); end
      ST_FDAT:   begin bus_valid = 1'b1; bus_rs = 1'b1; end
      ST_ONCMD:  begin bus_valid = 1'b1; bus_data = DATA_W'(CMD_DISP_ON); end
      default:   ;
    endcase
  end

  assign acc = bus_valid && bus_ready;

  // next-state
  always_comb begin
    st_d     = st_q;
    ent_d    = ent_q;
    pidx_d   = pidx_q;
    left_d   = left_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_long = 1'b0;
    fill_clr = 1'b0;
    fill_inc = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_CMD;
        ent_d = '0;
      end
      ST_CMD: if (acc) begin
        if (ent_cnt != '0) begin
          st_d   = ST_PAR;
          pidx_d = ent_base;
          left_d = ent_cnt - 1'b1;
        end else if (ent_last) begin
          st_d     = ST_SLEEP;
          tmr_load = 1'b1;
          tmr_long = 1'b1;
        end else begin
          ent_d = ent_q + 1'b1;
        end
      end
      ST_PAR: if (acc) begin
        if (left_q != '0) begin
          pidx_d = pidx_q + 1'b1;
          left_d = left_q - 1'b1;
        end else if (ent_last) begin
          st_d     = ST_SLEEP;
          tmr_load = 1'b1;
          tmr_long = 1'b1;
        end else begin
          st_d  = ST_CMD;
          ent_d = ent_q + 1'b1;
        end
      end
      ST_SLEEP: if (tmr_exp) st_d = ST_FCMD;
      ST_FCMD: if (acc) begin
        st_d     = ST_FDAT;
        fill_clr = 1'b1;
      end
      ST_FDAT: if (acc) begin
        fill_inc = 1'b1;
        if (fill_last) st_d = ST_ONCMD;
      end
      ST_ONCMD: if (acc) begin
        st_d     = ST_ONWAIT;
        tmr_load = 1'b1;
      end
      ST_ONWAIT: if (tmr_exp) st_d = ST_RAMCMD;
      ST_RAMCMD: if (acc) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign seq_en = (st_d != st_q) || acc;

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      ent_q  <= '0;
      pidx_q <= '0;
      left_q <= '0;
    end else if (seq_en) begin
      st_q   <= st_d;
      ent_q  <= ent_d;
      pidx_q <= pidx_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;

endmodule

// File: rtl/pnlcfg_streamer_chk.sv
module pnlcfg_streamer_chk #(
  parameter int DATA_W     = 18,
  parameter int SLEEP_CYC  = 6_000_000,
  parameter int ON_CYC     = 50_000,
  parameter int FILL_TOTAL = 96_000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_rs,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_ready,
  input logic              busy,
  input logic              done
);
  localparam int MAXC = (SLEEP_CYC > ON_CYC) ? SLEEP_CYC : ON_CYC;
  localparam int QW   = $clog2(MAXC + 1);
  localparam int FW   = $clog2(FILL_TOTAL + 1);

  logic          hs, hs_cmd, hs_par;
  logic [QW-1:0] qcnt;
  logic [FW-1:0] fcnt;
  logic          in_fill;

  assign hs     = bus_valid && bus_ready;
  assign hs_cmd = hs && !bus_rs;
  assign hs_par = hs && bus_rs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt    <= '0;
      fcnt    <= '0;
      in_fill <= 1'b0;
    end else begin
      if (hs_cmd && bus_data == DATA_W'(8'h11))      qcnt <= QW'(SLEEP_CYC);
      else if (hs_cmd && bus_data == DATA_W'(8'h29)) qcnt <= QW'(ON_CYC);
      else if (qcnt != '0)                           qcnt <= qcnt - 1'b1;

      if (hs_cmd && bus_data == DATA_W'(8'h2C)) begin
        in_fill <= 1'b1;
        fcnt    <= '0;
      end else if (hs_cmd) begin
        in_fill <= 1'b0;
      end else if (hs_par && in_fill) begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  // R3: stalled word is held
  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_data) && $stable(bus_rs));

  // R6, R8: bus silent during the settle windows
  a_r6_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt != '0 |-> !bus_valid);

  // R7: fill words are zero
  a_r7_fill_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hs_par && in_fill |-> bus_data == '0);

  // R7: full frame written before display-on
  a_r7_fill_count: assert property (@(posedge clk) disable iff (!rst_n)
    hs_cmd && in_fill && bus_data == DATA_W'(8'h29) |-> fcnt == FW'(FILL_TOTAL));

  // R9: one-cycle completion pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(hs_cmd && bus_data == DATA_W'(8'h2C)));

  // R1: nothing driven while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid);

endmodule

bind pnlcfg_streamer pnlcfg_streamer_chk #(
  .DATA_W    (DATA_W),
  .SLEEP_CYC (SLEEP_CYC),
  .ON_CYC    (ON_CYC),
  .FILL_TOTAL(COLS * ROWS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_rs   (bus_rs),
  .bus_data (bus_data),
  .bus_ready(bus_ready),
  .busy     (busy),
  .done     (done)
);

// File: tb/pnlcfg_streamer_bench.sv
`timescale 1ns/1ps
module pnlcfg_streamer_bench;
  localparam int DATA_W = 18;
  localparam int COLS   = 240;
  localparam int ROWS   = 400;
  localparam int FILL   = COLS * ROWS;
  localparam int SLP    = 200;
  localparam int ONW    = 40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              bus_valid, bus_rs, bus_ready, busy, done;
  logic [DATA_W-1:0] bus_data;

  always #10 clk = ~clk;

  pnlcfg_streamer #(
    .DATA_W(DATA_W), .COLS(COLS), .ROWS(ROWS), .SLEEP_CYC(SLP), .ON_CYC(ONW)
  ) u_pnlcfg_streamer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bus_valid(bus_valid), .bus_rs(bus_rs), .bus_data(bus_data),
    .bus_ready(bus_ready), .busy(busy), .done(done)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [8:0] exp_w [0:199];
  int ns = 0;
  int win_at = 0;
  int n_acc = 0;
  int last_acc_cyc = 0;
  int done_cyc = -1;
  int done_cnt = 0;
  bit stall_chk = 0;
  bit pend = 0;
  logic pend_rs;
  logic [DATA_W-1:0] pend_data;
  int wait_mark = -1;
  int wait_len = 0;
  string wait_tag;
  bit ready_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic add(input bit rs, input logic [7:0] b);
    exp_w[ns] = {rs, b};
    ns++;
  endtask

  task automatic build_script();
    logic [7:0] tim [5]  = '{8'h00, 8'h00, 8'h13, 8'h08, 8'h08};
    logic [7:0] gam [20] = '{8'h01, 8'h02, 8'h08, 8'h23, 8'h03, 8'h0C, 8'h00, 8'h06,
                             8'h00, 8'h00, 8'h01, 8'h00, 8'h0C, 8'h23, 8'h03, 8'h08,
                             8'h02, 8'h06, 8'h00, 8'h00};
    add(0, 8'hB0); add(1, 8'h00);
    add(0, 8'hB1); add(1, 8'h00);
    add(0, 8'hB3); add(1, 8'h02); add(1, 8'h00); add(1, 8'h00); add(1, 8'h00); add(1, 8'h02);
    add(0, 8'hB4); add(1, 8'h00);
    add(0, 8'hC0); add(1, 8'h0B); add(1, 8'h63); add(1, 8'h04); add(1, 8'h00); add(1, 8'h00);
    add(1, 8'h04); add(1, 8'h11); add(1, 8'h00); add(1, 8'h00);
    for (int c = 0; c < 3; c++) begin
      add(0, 8'hC1 + 8'(c));
      for (int k = 0; k < 5; k++) add(1, tim[k]);
    end
    add(0, 8'hC4); add(1, 8'h11); add(1, 8'h01); add(1, 8'h00); add(1, 8'h01);
    for (int c = 0; c < 3; c++) begin
      add(0, 8'hC8 + 8'(c));
      for (int k = 0; k < 20; k++) add(1, gam[k]);
    end
    add(0, 8'hD0); add(1, 8'h07); add(1, 8'hC5); add(1, 8'hDC); add(1, 8'h02); add(1, 8'h33); add(1, 8'h0A);
    add(0, 8'hD1); add(1, 8'h00); add(1, 8'h0F); add(1, 8'h02);
    for (int c = 0; c < 3; c++) begin
      add(0, 8'hD2 + 8'(c)); add(1, 8'h63); add(1, 8'h24);
    end
    add(0, 8'hD8); add(1, 8'h77); add(1, 8'h77);
    win_at = ns;
    add(0, 8'h35); add(1, 8'h00);
    add(0, 8'h44); add(1, 8'h00); add(1, 8'h00);
    add(0, 8'h2A); add(1, 8'h00); add(1, 8'h00); add(1, 8'h00); add(1, 8'hEF);
    add(0, 8'h2B); add(1, 8'h00); add(1, 8'h00); add(1, 8'h01); add(1, 8'h8F);
    add(0, 8'h11);
  endtask

  function automatic logic [8:0] exp_at(input int n);
    if (n < ns)             return exp_w[n];
    if (n == ns)            return {1'b0, 8'h2C};
    if (n <= ns + FILL)     return {1'b1, 8'h00};
    if (n == ns + FILL + 1) return {1'b0, 8'h29};
    return {1'b0, 8'h2C};
  endfunction

  function automatic string tag_at(input int n);
    if (n < win_at)         return "R4";
    if (n < ns - 1)         return "R5";
    if (n == ns - 1)        return "R6";
    if (n <= ns + FILL)     return "R7";
    return "R8";
  endfunction

  // bus ready pattern: one stall cycle in seven
  initial begin
    bus_ready = 1'b0;
    forever begin
      @(posedge clk); #3;
      bus_ready = ready_on && ((cyc % 7) != 3);
    end
  end

  // transaction monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        chk(bus_valid && bus_rs == pend_rs && bus_data == pend_data, "R3", "word held under stall",
            {bus_valid, bus_rs, bus_data}, {1'b1, pend_rs, pend_data});
      end
      pend      = bus_valid && !bus_ready;
      pend_rs   = bus_rs;
      pend_data = bus_data;

      if (wait_mark >= 0 && bus_valid) begin
        chk(cyc - wait_mark >= wait_len + 1 && cyc - wait_mark <= wait_len + 4, wait_tag,
            "settle gap", cyc - wait_mark, wait_len + 2);
        wait_mark = -1;
      end

      if (bus_valid && bus_ready) begin
        logic [8:0] e;
        e = exp_at(n_acc);
        if (n_acc >= ns + FILL + 3) begin
          chk(0, "R8", "transfer after end of run", n_acc, ns + FILL + 3);
        end else begin
          chk(bus_rs == e[8] && bus_data == DATA_W'(e[7:0]), tag_at(n_acc), "transfer value",
              {bus_rs, bus_data}, {e[8], DATA_W'(e[7:0])});
        end
        if (n_acc == ns - 1)        begin wait_mark = cyc; wait_len = SLP; wait_tag = "R6"; end
        if (n_acc == ns + FILL + 1) begin wait_mark = cyc; wait_len = ONW; wait_tag = "R8"; end
        n_acc++;
        last_acc_cyc = cyc;
      end

      if (done) begin
        done_cnt++;
        done_cyc = cyc;
        chk(!busy, "R9", "busy low with done", busy, 0);
        chk(cyc - last_acc_cyc == 1, "R9", "done one cycle after last accept",
            cyc - last_acc_cyc, 1);
      end
    end
  end

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !bus_valid, "R1", "outputs in reset", {busy, done, bus_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !done && !bus_valid, "R1", "outputs idle after reset", {busy, done, bus_valid}, 0);
  endtask

  task automatic t_run();
    ready_on = 1;
    @(posedge clk); #3 start = 1'b1;
    @(posedge clk); #3 start = 1'b0;
    @(negedge clk);
    chk(busy, "R2", "busy after start", busy, 1);
    wait (n_acc == ns + 500);
    @(posedge clk); #3 start = 1'b1;
    @(posedge clk); #3 start = 1'b0;
    @(negedge clk);
    chk(busy, "R2", "busy during run", busy, 1);
    wait (done_cnt != 0);
    repeat (30) @(negedge clk);
  endtask

  task automatic t_post();
    chk(n_acc == ns + FILL + 3, "R10", "transfer count under stalls", n_acc, ns + FILL + 3);
    chk(done_cnt == 1, "R9", "single done pulse", done_cnt, 1);
    chk(!busy && !bus_valid, "R2", "idle after run, extra start ignored", {busy, bus_valid}, 0);
    chk(ns == 147, "R4", "script length in bench", ns, 147);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    build_script();
    t_reset();
    t_run();
    t_post();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule